// File: doc/BRIEF.md
# Operand Address Generator

This unit computes the memory address of an instruction's operand for a 16-bit, word-addressed processor. An outside decoder pulses `start` with the instruction word, the already-incremented program counter, the value of the chosen base register, and a 2-bit mode. The unit then produces either a one-cycle address-valid pulse carrying the operand address, or nothing at all when the operand is an immediate or a register.

There are three addressing forms. The first adds a signed 9-bit field to the PC. The second adds a signed 6-bit field to the base register. The third is indirect: it forms the PC-relative address, reads that memory word through a request/valid handshake, and returns the word it read as the final operand address.

An instruction whose top nibble holds the reserved opcode is reported as illegal. No address is produced for it.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `addr_valid`, `rd_req` and `illegal` are all 0.
- R2: Mode 2'b00 (PC-relative): on the clock edge that samples `start`, `addr_out` becomes `pc_inc` plus `instr[8:0]` sign-extended to 16 bits. `addr_valid` is high for exactly that one following cycle.
- R3: Mode 2'b10 (base-offset): on the clock edge that samples `start`, `addr_out` becomes `base_val` plus `instr[5:0]` sign-extended to 16 bits. `addr_valid` is high for one cycle.
- R4: Mode 2'b01 (indirect): on the clock edge that samples `start`, `rd_req` rises and `rd_addr` becomes `pc_inc` plus sign-extended `instr[8:0]`. Both hold steady until `rd_valid` is sampled high.
- R5: In indirect mode, the edge that samples `rd_valid` drops `rd_req`, sets `addr_out` to `rd_data`, and raises `addr_valid` for one cycle.
- R6: Mode 2'b11 (none): a start raises neither `rd_req` nor `addr_valid`.
- R7: If `instr[15:12]` equals 4'b1101, a start gives a one-cycle `illegal` pulse and no `rd_req` or `addr_valid`, whatever the mode.
- R8: Every address sum wraps modulo 2^16, and there is no overflow indication.
- R9: While an indirect read is outstanding (`busy` high), `start` is ignored. The address still in flight and the final address are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute an address |
| mode | input | 2 | 00 PC-relative, 01 indirect, 10 base-offset, 11 none |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter |
| base_val | input | 16 | Value of the selected base register |
| rd_data | input | 16 | Word returned by memory for the indirect read |
| rd_valid | input | 1 | Pulse marking `rd_data` valid |
| rd_req | output | 1 | Indirect pointer read request |
| rd_addr | output | 16 | Address of the indirect pointer read |
| addr_valid | output | 1 | One-cycle pulse: `addr_out` is the operand address |
| addr_out | output | 16 | Operand address |
| illegal | output | 1 | One-cycle pulse for the reserved opcode |
| busy | output | 1 | Indirect read outstanding |

## Verification
A sequencer stuck in its wait state shows up at once as `busy` and `rd_req` that never drop after `rd_valid`, and no `addr_valid` pulse appears in the following cycle. A sequencer that returns to idle too early shows up as a request that vanishes before `rd_valid`, or as a new `start` that is obeyed while a read is outstanding. Either fault is visible within one cycle of the offending edge. A wrong extension width or sign shows up in the first address whose offset has its top bit set.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MODE_PCREL = 2'b00,
    MODE_IND   = 2'b01,
    MODE_BASE  = 2'b10,
    MODE_NONE  = 2'b11
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_offset_add.sv
module ea_offset_add #(
  parameter int W     = 16,
  parameter int OFF_W = 9
) (
  input  logic [W-1:0]     base,
  input  logic [OFF_W-1:0] offset,
  output logic [W-1:0]     sum
);
  localparam int EXT_W = W - OFF_W;

  logic [W-1:0] offset_ext;

  assign offset_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign sum        = base + offset_ext;
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         illegal_op,
  input  logic [W-1:0] pc_sum,
  input  logic [W-1:0] base_sum,
  input  logic [W-1:0] rd_data,
  input  logic         rd_valid,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  output logic         addr_valid,
  output logic [W-1:0] addr_out,
  output logic         illegal,
  output logic         busy
);
  ea_state_e    state_q;
  logic         rd_req_q;
  logic [W-1:0] rd_addr_q;
  logic         valid_q;
  logic [W-1:0] addr_q;
  logic         illegal_q;
  logic         accept;

  assign accept = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      valid_q   <= 1'b0;
      addr_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (illegal_op) begin
              illegal_q <= 1'b1;
            end else begin
              case (ea_mode_e'(mode))
                MODE_PCREL: begin
                  valid_q <= 1'b1;
                  addr_q  <= pc_sum;
                end
                MODE_BASE: begin
                  valid_q <= 1'b1;
                  addr_q  <= base_sum;
                end
                MODE_IND: begin
                  rd_req_q  <= 1'b1;
                  rd_addr_q <= pc_sum;
                  state_q   <= ST_WAIT;
                end
                default: ;
              endcase
            end
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            rd_req_q <= 1'b0;
            valid_q  <= 1'b1;
            addr_q   <= rd_data;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req     = rd_req_q;
  assign rd_addr    = rd_addr_q;
  assign addr_valid = valid_q;
  assign addr_out   = addr_q;
  assign illegal    = illegal_q;
  assign busy       = (state_q == ST_WAIT);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R4
  AST_IND_DONE: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_valid |=> addr_valid && !rd_req && addr_out == $past(rd_data)); // R5
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    accept && !illegal_op && mode == 2'b11 |=> !addr_valid && !rd_req); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    accept && illegal_op |=> illegal && !addr_valid && !rd_req); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    busy && !rd_valid |=> busy && !addr_valid && !illegal); // R9
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int         W           = 16,
  parameter int         PC_OFF_W    = 9,
  parameter int         BASE_OFF_W  = 6,
  parameter int         OPC_W       = 4,
  parameter logic [3:0] RESERVED_OPC = 4'b1101
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] rd_data,
  input  logic         rd_valid,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  output logic         addr_valid,
  output logic [W-1:0] addr_out,
  output logic         illegal,
  output logic         busy
);
  localparam int OPC_LO = W - OPC_W;

  logic [W-1:0] pc_sum;
  logic [W-1:0] base_sum;
  logic         illegal_op;
  logic         unused_mid;

  assign illegal_op = (instr[W-1:OPC_LO] == RESERVED_OPC[OPC_W-1:0]);
  assign unused_mid = ^instr[OPC_LO-1:PC_OFF_W];

  ea_offset_add #(.W(W), .OFF_W(PC_OFF_W)) u_pc_add (
    .base   (pc_inc),
    .offset (instr[PC_OFF_W-1:0]),
    .sum    (pc_sum)
  );

  ea_offset_add #(.W(W), .OFF_W(BASE_OFF_W)) u_base_add (
    .base   (base_val),
    .offset (instr[BASE_OFF_W-1:0]),
    .sum    (base_sum)
  );

  ea_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode       (mode),
    .illegal_op (illegal_op),
    .pc_sum     (pc_sum),
    .base_sum   (base_sum),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .addr_valid (addr_valid),
    .addr_out   (addr_out),
    .illegal    (illegal),
    .busy       (busy)
  );
endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic [15:0] instr = '0;
  logic [15:0] pc_inc = '0;
  logic [15:0] base_val = '0;
  logic [15:0] rd_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        addr_valid;
  logic [15:0] addr_out;
  logic        illegal;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ea_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .instr(instr),
    .pc_inc(pc_inc), .base_val(base_val), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_req(rd_req), .rd_addr(rd_addr),
    .addr_valid(addr_valid), .addr_out(addr_out), .illegal(illegal),
    .busy(busy)
  );

  function automatic logic [15:0] sx9(input logic [15:0] i);
    return {{7{i[8]}}, i[8:0]};
  endfunction
  function automatic logic [15:0] sx6(input logic [15:0] i);
    return {{10{i[5]}}, i[5:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [15:0] i,
                       input logic [15:0] pc, input logic [15:0] b);
    mode = m; instr = i; pc_inc = pc; base_val = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = 2'b11;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid in reset", {31'd0, addr_valid}, 0);
    check("R1 req in reset", {31'd0, rd_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {29'd0, addr_valid, rd_req, illegal}, 0);
  endtask

  task automatic t_pcrel(input logic [15:0] i, input logic [15:0] pc);
    issue(2'b00, i, pc, 16'h1234);
    check("R2 pcrel valid", {31'd0, addr_valid}, 1);
    check("R2 pcrel addr", {16'd0, addr_out}, {16'd0, pc + sx9(i)});
    check("R2 no req", {31'd0, rd_req}, 0);
    @(negedge clk);
    check("R2 valid one cycle", {31'd0, addr_valid}, 0);
  endtask

  task automatic t_base(input logic [15:0] i, input logic [15:0] b);
    issue(2'b10, i, 16'h7777, b);
    check("R3 base valid", {31'd0, addr_valid}, 1);
    check("R3 base addr", {16'd0, addr_out}, {16'd0, b + sx6(i)});
    @(negedge clk);
    check("R3 valid one cycle", {31'd0, addr_valid}, 0);
  endtask

  task automatic t_wrap();
    issue(2'b00, 16'h00FF, 16'hFFF0, 16'h0);
    check("R8 pcrel wrap", {16'd0, addr_out}, 32'h0000_00EF);
    issue(2'b10, 16'h0020, 16'h0000, 16'h0005);
    check("R8 base wrap", {16'd0, addr_out}, 32'h0000_FFE5);
  endtask

  task automatic t_indirect(input logic [15:0] i, input logic [15:0] pc,
                            input logic [15:0] ptr, input int wait_cyc);
    issue(2'b01, i, pc, 16'h0);
    check("R4 req raised", {31'd0, rd_req}, 1);
    check("R4 req addr", {16'd0, rd_addr}, {16'd0, pc + sx9(i)});
    check("R4 no early valid", {31'd0, addr_valid}, 0);
    for (int k = 0; k < wait_cyc; k++) @(negedge clk);
    check("R4 req held", {15'd0, rd_req, rd_addr}, {15'd0, 1'b1, pc + sx9(i)});
    rd_data = ptr; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = 16'hDEAD;
    check("R5 final valid", {31'd0, addr_valid}, 1);
    check("R5 final addr", {16'd0, addr_out}, {16'd0, ptr});
    check("R5 req dropped", {30'd0, rd_req, busy}, 0);
    @(negedge clk);
    check("R5 valid one cycle", {31'd0, addr_valid}, 0);
  endtask

  task automatic t_none();
    issue(2'b11, 16'h01FF, 16'h1000, 16'h2000);
    check("R6 none quiet", {30'd0, addr_valid, rd_req}, 0);
    @(negedge clk);
    check("R6 none still quiet", {30'd0, addr_valid, rd_req}, 0);
  endtask

  task automatic t_illegal(input logic [1:0] m);
    issue(m, 16'hD005, 16'h1000, 16'h2000);
    check("R7 illegal pulse", {31'd0, illegal}, 1);
    check("R7 nothing else", {29'd0, addr_valid, rd_req, busy}, 0);
    @(negedge clk);
    check("R7 pulse ends", {31'd0, illegal}, 0);
  endtask

  task automatic t_busy_ignore();
    issue(2'b01, 16'h0010, 16'h0300, 16'h0);
    issue(2'b00, 16'h0001, 16'h5000, 16'h0);
    check("R9 start ignored", {31'd0, addr_valid}, 0);
    check("R9 req kept", {15'd0, rd_req, rd_addr}, {15'd0, 1'b1, 16'h0310});
    issue(2'b10, 16'hD001, 16'h0, 16'h0);
    check("R9 illegal ignored", {31'd0, illegal}, 0);
    rd_data = 16'hABCD; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R9 final addr unchanged", {15'd0, addr_valid, addr_out}, {15'd0, 1'b1, 16'hABCD});
  endtask

  initial begin
    t_reset();
    t_pcrel(16'h0005, 16'h3001);
    t_pcrel(16'h01F0, 16'h3001);
    t_base(16'h001F, 16'h4000);
    t_base(16'h0030, 16'h4000);
    t_wrap();
    t_indirect(16'h0002, 16'h3000, 16'h8123, 0);
    t_indirect(16'h0180, 16'h0100, 16'h0042, 3);
    t_none();
    t_illegal(2'b00);
    t_illegal(2'b01);
    t_busy_ignore();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule